// File: doc/BRIEF.md
# Flash Command Register State Machine

This block is the device-side command interface of a byte-wide flash memory whose erase clears the whole array. A host drives a bus made of chip select (`ce_n`), write strobe (`we_n`) and read strobe (`oe_n`), all active low, together with an address, a write byte and a program-voltage-present flag. Every input is sampled on the block clock. A write is detected from the edges of `we_n` while `ce_n` is low. The byte that is present at the rising edge of the write strobe is the command. The address that was present at the falling edge is the one the block may latch.

Commands select read-array mode, identifier reads, a two-write erase sequence, erase verify, program setup, program verify and read. Erase and program both start on the rising strobe edge of one write and finish on the rising strobe edge of the next write, which is normally the matching verify command. A small internal array model shows the effect of each operation. Erase completion sets every byte to FFH. Program completion ANDs the latched data into the latched byte.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (read array), both busy flags are low and every array byte reads FFH.
- R2: `dout` is 00H unless both `ce_n` and `oe_n` are low. In read-array mode (`mode` 0, also in modes 2, 3, 5 and 6) it returns the array byte at `addr`.
- R3: Writing 90H gives `mode` 1. A read at address 0 then returns 89H, a read at address 1 returns BDH and a read at any other address returns 00H. Reads leave the mode unchanged, and it stays 1 until another command write.
- R4: Writing 20H gives `mode` 2. A second 20H written while `vpp_ok` is high gives `mode` 3 and raises `erase_busy` at the rising strobe edge of that write.
- R5: A second 20H written while `vpp_ok` is low returns to `mode` 0 without starting an erase, and the array is unchanged.
- R6: In `mode` 2, a write of any byte other than 20H returns to `mode` 0 without erasing. This includes codes that would otherwise be valid commands.
- R7: Writing A0H gives `mode` 4 and latches `lat_addr` from the address present at that write's falling strobe edge. If an erase was running, it ends and every byte becomes FFH. Reads in `mode` 4 return the byte at `lat_addr`, whatever the value of `addr`.
- R8: Writing 40H gives `mode` 5. The next write latches `lat_addr` from its falling-edge address and `lat_data` from its rising-edge byte, then gives `mode` 6 with `prog_busy` high.
- R9: Writing C0H gives `mode` 7 and leaves `lat_addr` unchanged. If programming was running, it ends, `prog_busy` falls and the latched byte becomes its old value AND `lat_data`. Reads in `mode` 7 return the byte at `lat_addr`.
- R10: Writing 00H or FFH gives `mode` 0. Any byte other than 00H, FFH, 90H, 20H, A0H, 40H or C0H, written outside modes 2 and 5, also gives `mode` 0.
- R11: Strobe pulses on `we_n` while `ce_n` is high have no effect on the mode, the latches or the array.
- R12: `mode` changes only in the cycle after a rising write-strobe edge is sampled, and `erase_busy` and `prog_busy` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bus inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| vpp_ok | input | 1 | High when program voltage is present |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write byte (command or program data) |
| dout | output | 8 | Read byte |
| mode | output | 3 | Current mode: 0 read, 1 ident, 2 erase setup, 3 erasing, 4 erase verify, 5 program setup, 6 programming, 7 program verify |
| erase_busy | output | 1 | Erase operation running |
| prog_busy | output | 1 | Program operation running |
| lat_addr | output | ADDR_W | Latched operation address |
| lat_data | output | 8 | Latched program data |

## Verification
The bench changes `addr` and `din` between the two strobe edges of a write. A design that latched the address on the rising edge, or the data on the falling edge, would therefore read back the wrong byte after program verify. It attempts the erase sequence with the program voltage absent, and aborts it with a valid but different second code. A design that erased anyway would lose previously programmed bytes. A design that treated 40H as program setup would report mode 5 instead of 0. Verify reads are issued at a bus address different from the latched one, to catch designs that use the live address. Strobes with chip select high, and random sequences checked against a bench model of the array, expose writes that leak through or state that drifts.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OPC_READ_A   = 8'h00;
    localparam logic [BYTE_W-1:0] OPC_READ_B   = 8'hFF;
    localparam logic [BYTE_W-1:0] OPC_IDENT    = 8'h90;
    localparam logic [BYTE_W-1:0] OPC_ERASE    = 8'h20;
    localparam logic [BYTE_W-1:0] OPC_ERS_VFY  = 8'hA0;
    localparam logic [BYTE_W-1:0] OPC_PROGRAM  = 8'h40;
    localparam logic [BYTE_W-1:0] OPC_PGM_VFY  = 8'hC0;

    localparam logic [BYTE_W-1:0] MAKER_CODE   = 8'h89;
    localparam logic [BYTE_W-1:0] DEVICE_CODE  = 8'hBD;
    localparam logic [BYTE_W-1:0] ERASED_BYTE  = 8'hFF;

    typedef enum logic [2:0] {
        MODE_READ        = 3'd0,
        MODE_IDENT       = 3'd1,
        MODE_ERS_SETUP   = 3'd2,
        MODE_ERASING     = 3'd3,
        MODE_ERS_VERIFY  = 3'd4,
        MODE_PGM_SETUP   = 3'd5,
        MODE_PROGRAMMING = 3'd6,
        MODE_PGM_VERIFY  = 3'd7
    } mode_e;

    typedef enum logic [2:0] {
        CMD_READ,
        CMD_IDENT,
        CMD_ERASE,
        CMD_ERS_VERIFY,
        CMD_PROGRAM,
        CMD_PGM_VERIFY,
        CMD_INVALID
    } cmd_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } we_evt_t;

    function automatic cmd_e decode_cmd(input logic [BYTE_W-1:0] code);
        cmd_e c;
        case (code)
            OPC_READ_A, OPC_READ_B: c = CMD_READ;
            OPC_IDENT:              c = CMD_IDENT;
            OPC_ERASE:              c = CMD_ERASE;
            OPC_ERS_VFY:            c = CMD_ERS_VERIFY;
            OPC_PROGRAM:            c = CMD_PROGRAM;
            OPC_PGM_VFY:            c = CMD_PGM_VERIFY;
            default:                c = CMD_INVALID;
        endcase
        return c;
    endfunction

    function automatic logic reads_latched(input mode_e m);
        return (m == MODE_ERS_VERIFY) || (m == MODE_PGM_VERIFY);
    endfunction

endpackage

// File: rtl/flash_we_edge.sv
module flash_we_edge
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output we_evt_t           evt,
    output logic [ADDR_W-1:0] cap_addr
);

    logic we_prev;

    always_comb begin
        evt.fall = !ce_n && we_prev && !we_n;
        evt.rise = !ce_n && !we_prev && we_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            we_prev  <= 1'b1;
            cap_addr <= '0;
        end else begin
            we_prev <= we_n;
            if (evt.fall) cap_addr <= addr;
        end
    end

    // R7
    fall_captures_addr_chk: assert property (@(posedge clk) disable iff (rst)
        evt.fall |=> cap_addr == $past(addr));

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  we_evt_t           evt,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [BYTE_W-1:0] din,
    input  logic              vpp_ok,
    output mode_e             mode,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [BYTE_W-1:0] lat_data,
    output logic              erase_busy,
    output logic              prog_busy,
    output logic              erase_commit,
    output logic              prog_commit
);

    mode_e             mode_d;
    logic [ADDR_W-1:0] addr_d;
    logic [BYTE_W-1:0] data_d;
    cmd_e              cmd;

    assign cmd          = decode_cmd(din);
    assign erase_busy   = (mode == MODE_ERASING);
    assign prog_busy    = (mode == MODE_PROGRAMMING);
    assign erase_commit = evt.rise && erase_busy;
    assign prog_commit  = evt.rise && prog_busy;

    always_comb begin
        mode_d = mode;
        addr_d = lat_addr;
        data_d = lat_data;
        if (evt.rise) begin
            case (mode)
                MODE_PGM_SETUP: begin
                    mode_d = MODE_PROGRAMMING;
                    addr_d = cap_addr;
                    data_d = din;
                end
                MODE_ERS_SETUP: begin
                    mode_d = (cmd == CMD_ERASE && vpp_ok) ? MODE_ERASING : MODE_READ;
                end
                default: begin
                    case (cmd)
                        CMD_IDENT:      mode_d = MODE_IDENT;
                        CMD_ERASE:      mode_d = MODE_ERS_SETUP;
                        CMD_ERS_VERIFY: begin
                            mode_d = MODE_ERS_VERIFY;
                            addr_d = cap_addr;
                        end
                        CMD_PROGRAM:    mode_d = MODE_PGM_SETUP;
                        CMD_PGM_VERIFY: mode_d = MODE_PGM_VERIFY;
                        default:        mode_d = MODE_READ;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= MODE_READ;
            lat_addr <= '0;
            lat_data <= '0;
        end else begin
            mode     <= mode_d;
            lat_addr <= addr_d;
            lat_data <= data_d;
        end
    end

    // R4
    erase_needs_vpp_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(erase_busy) |-> $past(vpp_ok));

    // R8
    pgm_data_at_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(prog_busy) |-> lat_data == $past(din));

    // R9
    pgm_addr_held_chk: assert property (@(posedge clk) disable iff (rst)
        (prog_busy && $past(prog_busy)) |-> $stable(lat_addr));

    // R12
    mode_moves_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != $past(mode)) |-> $past(evt.rise));

    // R12
    busy_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({erase_busy, prog_busy}));

endmodule

// File: rtl/flash_array_model.sv
module flash_array_model
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              erase_commit,
    input  logic              prog_commit,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  logic [BYTE_W-1:0] pgm_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst || erase_commit) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
        end else if (prog_commit) begin
            mem[pgm_addr] <= mem[pgm_addr] & pgm_data;
        end
    end

    // R7
    erase_fills_chk: assert property (@(posedge clk) disable iff (rst)
        erase_commit |=> (mem[0] == ERASED_BYTE) && (mem[DEPTH-1] == ERASED_BYTE));

    // R9
    program_ands_chk: assert property (@(posedge clk) disable iff (rst)
        prog_commit |=> mem[$past(pgm_addr)] == ($past(mem[pgm_addr]) & $past(pgm_data)));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              vpp_ok,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic [2:0]        mode,
    output logic              erase_busy,
    output logic              prog_busy,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [7:0]        lat_data
);

    we_evt_t           evt;
    logic [ADDR_W-1:0] cap_addr;
    mode_e             mode_q;
    logic              erase_commit;
    logic              prog_commit;
    logic [ADDR_W-1:0] rd_addr;
    logic [BYTE_W-1:0] rd_data;

    flash_we_edge #(.ADDR_W(ADDR_W)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .addr     (addr),
        .evt      (evt),
        .cap_addr (cap_addr)
    );

    flash_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .cap_addr     (cap_addr),
        .din          (din),
        .vpp_ok       (vpp_ok),
        .mode         (mode_q),
        .lat_addr     (lat_addr),
        .lat_data     (lat_data),
        .erase_busy   (erase_busy),
        .prog_busy    (prog_busy),
        .erase_commit (erase_commit),
        .prog_commit  (prog_commit)
    );

    assign rd_addr = reads_latched(mode_q) ? lat_addr : addr;

    flash_array_model #(.ADDR_W(ADDR_W)) u_array (
        .clk          (clk),
        .rst          (rst),
        .erase_commit (erase_commit),
        .prog_commit  (prog_commit),
        .pgm_addr     (lat_addr),
        .pgm_data     (lat_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data)
    );

    assign mode = mode_q;

    always_comb begin
        dout = '0;
        if (!ce_n && !oe_n) begin
            if (mode_q == MODE_IDENT) begin
                if (addr == ADDR_W'(0))      dout = MAKER_CODE;
                else if (addr == ADDR_W'(1)) dout = DEVICE_CODE;
                else                         dout = '0;
            end else begin
                dout = rd_data;
            end
        end
    end

    // R11
    ce_high_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> $stable(mode) && $stable(lat_addr) && $stable(lat_data));

    // R2
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (ce_n || oe_n) |-> dout == 8'h00);

endmodule

// File: tb/flash_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb;

    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, vpp_ok = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic [2:0]    mode;
    logic          erase_busy, prog_busy;
    logic [AW-1:0] lat_addr;
    logic [7:0]    lat_data;

    int vectors = 0;
    int fails = 0;

    logic [7:0]    em_mem [DEPTH];
    logic [2:0]    em_mode;
    logic [AW-1:0] em_la;
    logic [7:0]    em_ld;

    always #2 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .vpp_ok(vpp_ok), .addr(addr), .din(din), .dout(dout), .mode(mode),
        .erase_busy(erase_busy), .prog_busy(prog_busy),
        .lat_addr(lat_addr), .lat_data(lat_data)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [AW-1:0] a);
        if (em_mode == 3'd1) return (a == 0) ? 8'h89 : (a == 1) ? 8'hBD : 8'h00;
        if (em_mode == 3'd4 || em_mode == 3'd7) return em_mem[em_la];
        return em_mem[a];
    endfunction

    task automatic model_write(input logic [AW-1:0] af, input logic [7:0] dr);
        case (em_mode)
            3'd5: begin em_mode = 3'd6; em_la = af; em_ld = dr; end
            3'd2: em_mode = (dr == 8'h20 && vpp_ok) ? 3'd3 : 3'd0;
            default: begin
                if (em_mode == 3'd3) for (int i = 0; i < DEPTH; i++) em_mem[i] = 8'hFF;
                if (em_mode == 3'd6) em_mem[em_la] = em_mem[em_la] & em_ld;
                case (dr)
                    8'h90: em_mode = 3'd1;
                    8'h20: em_mode = 3'd2;
                    8'hA0: begin em_mode = 3'd4; em_la = af; end
                    8'h40: em_mode = 3'd5;
                    8'hC0: em_mode = 3'd7;
                    default: em_mode = 3'd0;
                endcase
            end
        endcase
    endtask

    task automatic bus_write(input logic [AW-1:0] af, input logic [AW-1:0] ar,
                             input logic [7:0] df, input logic [7:0] dr, input logic sel);
        @(negedge clk);
        ce_n = !sel; addr = af; din = df; we_n = 1'b0;
        @(negedge clk);
        addr = ar; din = dr; we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1;
        if (sel) model_write(af, dr);
    endtask

    task automatic wr(input logic [7:0] d);
        bus_write(4'd0, 4'd0, d, d, 1'b1);
    endtask

    task automatic check_state(input string tag);
        check({tag, " mode"}, {5'd0, mode}, {5'd0, em_mode});
        check({tag, " erase_busy"}, {7'd0, erase_busy}, {7'd0, em_mode == 3'd3});
        check({tag, " prog_busy"}, {7'd0, prog_busy}, {7'd0, em_mode == 3'd6});
    endtask

    task automatic read_chk(input logic [AW-1:0] a, input string tag);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; addr = a;
        #1 check({tag, " read"}, dout, exp_read(a));
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 8'h01, 8'h00);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED1234);
        for (int i = 0; i < DEPTH; i++) em_mem[i] = 8'hFF;
        em_mode = 3'd0; em_la = '0; em_ld = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check_state("R1");
        read_chk(4'd5, "R1");
        read_chk(4'd15, "R1");
        // R2 no output without read strobe
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; addr = 4'd5;
        #1 check("R2 oe_n high", dout, 8'h00);
        @(negedge clk); ce_n = 1'b1;

        // R3 identifier
        wr(8'h90); check_state("R3");
        read_chk(4'd0, "R3"); read_chk(4'd1, "R3"); read_chk(4'd2, "R3");
        check_state("R3 persists");
        // R10 unrecognised code
        wr(8'h55); check_state("R10");
        wr(8'h90); wr(8'hFF); check_state("R10 FFH");

        // R8 program, address at fall, data at rise
        wr(8'h40); check_state("R8 setup");
        bus_write(4'd3, 4'd9, 8'h11, 8'h5A, 1'b1);
        check_state("R8");
        check("R8 lat_addr", {4'd0, lat_addr}, 8'd3);
        check("R8 lat_data", lat_data, 8'h5A);
        // R9 verify, no new address
        bus_write(4'd7, 4'd7, 8'hC0, 8'hC0, 1'b1);
        check_state("R9");
        check("R9 lat_addr", {4'd0, lat_addr}, 8'd3);
        read_chk(4'd12, "R9 verify");
        wr(8'h40); bus_write(4'd3, 4'd3, 8'hF0, 8'hF0, 1'b1); wr(8'hC0);
        read_chk(4'd0, "R9 AND");
        wr(8'h00); read_chk(4'd3, "R2 array");

        // R5 erase blocked without program voltage
        vpp_ok = 1'b0;
        wr(8'h20); check_state("R4 setup"); wr(8'h20); check_state("R5");
        read_chk(4'd3, "R5 kept");
        // R6 abort by other code
        vpp_ok = 1'b1;
        wr(8'h20); wr(8'h40); check_state("R6");
        read_chk(4'd3, "R6 kept");
        // R4 / R7 erase
        wr(8'h20); wr(8'h20); check_state("R4");
        bus_write(4'd3, 4'd8, 8'hA0, 8'hA0, 1'b1);
        check_state("R7");
        check("R7 lat_addr", {4'd0, lat_addr}, 8'd3);
        read_chk(4'd0, "R7 verify");

        // R11 writes with chip select high
        wr(8'h90);
        bus_write(4'd0, 4'd0, 8'h20, 8'h20, 1'b0);
        check_state("R11");
        read_chk(4'd1, "R11");

        // random sequences, R12 via mode checks after each step
        for (int n = 0; n < 80; n++) begin
            int op;
            logic [AW-1:0] ra;
            logic [7:0] rd;
            op = $urandom % 6;
            ra = AW'($urandom);
            rd = 8'($urandom);
            vpp_ok = ($urandom % 4) != 0;
            case (op)
                0: begin wr(8'h40); bus_write(ra, AW'($urandom), 8'($urandom), rd, 1'b1); wr(8'hC0); end
                1: wr(8'h90);
                2: wr(rd);
                3: begin wr(8'h20); wr(8'h20); bus_write(ra, AW'($urandom), 8'hA0, 8'hA0, 1'b1); end
                4: bus_write(ra, ra, rd, rd, 1'b0);
                default: wr(8'h00);
            endcase
            check_state("R12 random");
            read_chk(AW'($urandom), "R2 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule